// File: doc/BRIEF.md
# Timer Subsystem Configuration and Freeze Unit

This block sits between a CPU register bus and the internal bus of a timer subsystem. It holds one 16-bit configuration word, and the timer submodules behind it see three things derived from that word: a freeze request, an interrupt arbitration number and a time-base selection. A software stop bit forces the freeze on. A freeze-enable bit lets an external freeze input (typically a debug halt) reach the submodules. The freeze output comes from a flop. Register access keeps working while the submodules are frozen, so software can always clear the stop bit.

The block also forms the 8-bit interrupt vector. The upper two bits come from a programmable base field in the configuration word. The lower six bits are supplied by whichever submodule is requesting service. Two further word offsets, a test slot and a time-base slot, are decoded but hold no storage. Every other offset is unmapped.

Top module: `tmr_cfg_unit`

## Requirements
- R1: After reset the configuration word reads 0x0000, and `sub_freeze`, `irq_arb` and `tb_select` are all zero.
- R2: A write to byte offset 0x0 stores bits 15, 14, 12:11, 10:8, 2 and 0 (mask 0xDF05). All other bits read as zero and ignore written values.
- R3: While bit 15 (stop) is set, `sub_freeze` is 1 whatever `ext_freeze` does. `sub_freeze` changes on the clock edge after the edge that commits the write.
- R4: While bit 15 is clear and bit 14 (freeze enable) is set, `sub_freeze` equals `ext_freeze` as sampled at the previous rising edge. While both bits are clear, `ext_freeze` has no effect and `sub_freeze` is 0.
- R5: A freeze caused by stop persists until stop is cleared by a write or by reset. Clearing stop and dropping `ext_freeze` in the same cycle releases the freeze one edge later.
- R6: Register reads and writes behave normally while `sub_freeze` is 1.
- R7: `irq_vector` = {bits 12:11, `sub_num`}, giving bases 0x00, 0x40, 0x80 and 0xC0 for codes 00, 01, 10 and 11.
- R8: Offsets 0x2 (test slot) and 0x4 (time-base slot) read as zero, and writes to them leave the configuration word unchanged.
- R9: Any other offset, odd offsets included, reads as zero, and a write to it has no side effect.
- R10: `irq_arb` equals bits 10:8. `tb_select` equals {bit 2, bit 0}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| ext_freeze | input | 1 | External freeze request |
| sub_freeze | output | 1 | Registered freeze to the timer submodules |
| sub_num | input | SUB_NUM_W | Low vector bits from the requesting submodule |
| irq_vector | output | SUB_NUM_W+2 | Formed interrupt vector |
| irq_arb | output | 3 | Interrupt arbitration number |
| tb_select | output | 2 | Time-base selection |

## Verification
Two freeze sources can change in the same cycle: a bus write that clears stop, and a fall of `ext_freeze` while freeze enable stays set. The bench drives both on one falling edge. It expects `sub_freeze` to stay high for exactly one more edge, because the flop still samples the old stop bit, and then to drop. The bench also reads and rewrites the configuration word while the freeze is held. It checks that the bus access is unaffected and that the freeze output does not glitch.

// File: rtl/tmr_cfg_pkg.sv
package tmr_cfg_pkg;

   localparam int REG_W     = 16;
   localparam int BASE_W    = 2;
   localparam int ARB_W     = 3;
   localparam int TBS_W     = 2;

   localparam int POS_STOP  = 15;
   localparam int POS_FEN   = 14;
   localparam int POS_BASE  = 11;
   localparam int POS_ARB   = 8;
   localparam int POS_TBS1  = 2;
   localparam int POS_TBS0  = 0;

   localparam int OFF_CFG   = 0;
   localparam int OFF_TEST  = 2;
   localparam int OFF_TBASE = 4;

   typedef struct packed {
      logic               stop;
      logic               frz_en;
      logic [BASE_W-1:0]  base;
      logic [ARB_W-1:0]   arb;
      logic [TBS_W-1:0]   tbs;
   } cfg_t;

   function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
      logic [REG_W-1:0] w;
      w = '0;
      w[POS_STOP]                  = c.stop;
      w[POS_FEN]                   = c.frz_en;
      w[POS_BASE +: BASE_W]        = c.base;
      w[POS_ARB  +: ARB_W]         = c.arb;
      w[POS_TBS1]                  = c.tbs[1];
      w[POS_TBS0]                  = c.tbs[0];
      return w;
   endfunction

   function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
      cfg_t c;
      c.stop   = w[POS_STOP];
      c.frz_en = w[POS_FEN];
      c.base   = w[POS_BASE +: BASE_W];
      c.arb    = w[POS_ARB  +: ARB_W];
      c.tbs    = {w[POS_TBS1], w[POS_TBS0]};
      return c;
   endfunction

   localparam cfg_t             CFG_ALL1  = '1;
   localparam logic [REG_W-1:0] CFG_WMASK = cfg_pack(CFG_ALL1);

endpackage

// File: rtl/tcfg_regs.sv
module tcfg_regs
   import tmr_cfg_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  rdata_o,
   output cfg_t              cfg_o
);

   localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
   localparam logic [ADDR_W-1:0] A_TEST  = ADDR_W'(OFF_TEST);
   localparam logic [ADDR_W-1:0] A_TBASE = ADDR_W'(OFF_TBASE);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("tcfg_regs: ADDR_W must reach offset 0x4");
   end

   cfg_t cfg_q;
   logic hit_cfg;

   assign hit_cfg = sel_i && (addr_i == A_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (hit_cfg && wr_i) begin
         cfg_q <= cfg_unpack(wdata_i);
      end
   end

   always_comb begin
      rdata_o = '0;
      if (sel_i && !wr_i) begin
         unique case (addr_i)
            A_CFG:   rdata_o = cfg_pack(cfg_q);
            A_TEST:  rdata_o = '0;
            A_TBASE: rdata_o = '0;
            default: rdata_o = '0;
         endcase
      end
   end

   assign cfg_o = cfg_q;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o & ~CFG_WMASK) == '0);                               // R2
   AST_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && addr_i != A_CFG) |-> rdata_o == '0);               // R8
   AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && wr_i && addr_i != A_CFG) |=> $stable(cfg_q));      // R9

endmodule

// File: rtl/tcfg_freeze.sv
module tcfg_freeze #(
   parameter bit SYNC_EXT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_i,
   input  logic frz_en_i,
   input  logic ext_frz_i,
   output logic frz_o
);

   logic ext_s;
   logic frz_q;

   if (SYNC_EXT) begin : g_ext_sync
      logic ext_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_q <= 1'b0;
         else        ext_q <= ext_frz_i;
      end
      assign ext_s = ext_q;
   end else begin : g_ext_direct
      assign ext_s = ext_frz_i;

      AST_FEN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (!stop_i && frz_en_i) |=> (frz_o == $past(ext_frz_i)));  // R4
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frz_q <= 1'b0;
      else        frz_q <= stop_i | (frz_en_i & ext_s);
   end

   assign frz_o = frz_q;

   AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> frz_o);                                           // R3
   AST_EXT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_i && !frz_en_i) |=> !frz_o);                          // R4

endmodule

// File: rtl/tcfg_vector.sv
module tcfg_vector #(
   parameter int HI_W    = 2,
   parameter int LO_W    = 6,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [HI_W-1:0]      base_i,
   input  logic [LO_W-1:0]      sub_i,
   output logic [HI_W+LO_W-1:0] vec_o
);

   localparam int VEC_W = HI_W + LO_W;

   if (LO_W < 1 || HI_W < 1) begin : g_bad_w
      $error("tcfg_vector: both vector parts need at least one bit");
   end

   logic [VEC_W-1:0] vec_c;
   assign vec_c = {base_i, sub_i};

   if (REG_OUT) begin : g_reg
      logic [VEC_W-1:0] vec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vec_q <= '0;
         else        vec_q <= vec_c;
      end
      assign vec_o = vec_q;
   end else begin : g_comb
      assign vec_o = vec_c;
   end

endmodule

// File: rtl/tmr_cfg_unit.sv
module tmr_cfg_unit
   import tmr_cfg_pkg::*;
#(
   parameter int ADDR_W       = 4,
   parameter int SUB_NUM_W    = 6,
   parameter bit SYNC_EXT_FRZ = 1'b0,
   parameter bit VEC_REG_OUT  = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [15:0]                 bus_wdata,
   output logic [15:0]                 bus_rdata,
   input  logic                        ext_freeze,
   output logic                        sub_freeze,
   input  logic [SUB_NUM_W-1:0]        sub_num,
   output logic [SUB_NUM_W+BASE_W-1:0] irq_vector,
   output logic [2:0]                  irq_arb,
   output logic [1:0]                  tb_select
);

   if (REG_W != 16) begin : g_bad_reg
      $error("tmr_cfg_unit: register width must be 16");
   end

   cfg_t cfg;

   tcfg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (bus_sel),
      .wr_i    (bus_wr),
      .addr_i  (bus_addr),
      .wdata_i (bus_wdata),
      .rdata_o (bus_rdata),
      .cfg_o   (cfg)
   );

   tcfg_freeze #(.SYNC_EXT(SYNC_EXT_FRZ)) u_freeze (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_i    (cfg.stop),
      .frz_en_i  (cfg.frz_en),
      .ext_frz_i (ext_freeze),
      .frz_o     (sub_freeze)
   );

   tcfg_vector #(.HI_W(BASE_W), .LO_W(SUB_NUM_W), .REG_OUT(VEC_REG_OUT)) u_vec (
      .clk    (clk),
      .rst_n  (rst_n),
      .base_i (cfg.base),
      .sub_i  (sub_num),
      .vec_o  (irq_vector)
   );

   assign irq_arb   = cfg.arb;
   assign tb_select = cfg.tbs;

   if (!VEC_REG_OUT) begin : g_vec_chk
      AST_VEC_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
         irq_vector[SUB_NUM_W-1:0] == sub_num &&
         irq_vector[SUB_NUM_W +: BASE_W] == bus_rdata[POS_BASE +: BASE_W]
         || !(bus_sel && !bus_wr && bus_addr == '0));               // R7
   end

   AST_RD_WHILE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_freeze && bus_sel && bus_wr && bus_addr == '0) |=>
      (irq_arb == $past(bus_wdata[POS_ARB +: ARB_W])));             // R6

endmodule

// File: tb/test_tmr_cfg_unit.sv
module test_tmr_cfg_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ext_freeze = 1'b0;
   logic        sub_freeze;
   logic [5:0]  sub_num = '0;
   logic [7:0]  irq_vector;
   logic [2:0]  irq_arb;
   logic [1:0]  tb_select;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   tmr_cfg_unit i_tmr_cfg_unit (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_freeze(ext_freeze), .sub_freeze(sub_freeze), .sub_num(sub_num),
      .irq_vector(irq_vector), .irq_arb(irq_arb), .tb_select(tb_select)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      bus_read(4'h0, d);
      chk("R1 cfg after reset", d, 16'h0000);
      chk("R1 freeze after reset", {15'd0, sub_freeze}, 16'h0);
      chk("R1 arb/tb after reset", {11'd0, irq_arb, tb_select}, 16'h0);
   endtask

   task automatic t_fields;
      logic [15:0] d;
      bus_write(4'h0, 16'hFFFF);
      bus_read(4'h0, d);
      chk("R2 reserved bits read zero", d, 16'hDF05);
      chk("R10 arb all ones", {13'd0, irq_arb}, 16'h7);
      chk("R10 tb all ones", {14'd0, tb_select}, 16'h3);
      bus_write(4'h0, 16'h0204);
      bus_read(4'h0, d);
      chk("R2 partial write", d, 16'h0204);
      chk("R10 arb bits 10:8", {13'd0, irq_arb}, 16'h2);
      chk("R10 tb bit2 high", {14'd0, tb_select}, 16'h2);
      bus_write(4'h0, 16'h20FB);
      bus_read(4'h0, d);
      chk("R2 reserved-only write", d, 16'h0001);
      chk("R10 tb bit0 low", {14'd0, tb_select}, 16'h1);
      bus_write(4'h0, 16'h0000);
   endtask

   task automatic t_stop;
      logic [15:0] d;
      ext_freeze = 1'b0;
      bus_write(4'h0, 16'h8000);
      chk("R3 freeze one edge later", {15'd0, sub_freeze}, 16'h0);
      @(negedge clk);
      chk("R3 stop asserts freeze", {15'd0, sub_freeze}, 16'h1);
      ext_freeze = 1'b1;
      @(negedge clk);
      ext_freeze = 1'b0;
      @(negedge clk);
      chk("R3 ext low does not release", {15'd0, sub_freeze}, 16'h1);
      bus_write(4'h0, 16'h8305);
      bus_read(4'h0, d);
      chk("R6 readback while frozen", d, 16'h8305);
      chk("R6 arb updated while frozen", {13'd0, irq_arb}, 16'h3);
      repeat (20) @(negedge clk);
      chk("R5 stop freeze persists", {15'd0, sub_freeze}, 16'h1);
      bus_write(4'h0, 16'h0000);
      @(negedge clk);
      chk("R5 clear stop releases", {15'd0, sub_freeze}, 16'h0);
   endtask

   task automatic t_fen;
      bus_write(4'h0, 16'h4000);
      @(negedge clk);
      chk("R4 enabled, ext low", {15'd0, sub_freeze}, 16'h0);
      ext_freeze = 1'b1;
      #1 chk("R4 not before edge", {15'd0, sub_freeze}, 16'h0);
      @(negedge clk);
      chk("R4 follows ext high", {15'd0, sub_freeze}, 16'h1);
      ext_freeze = 1'b0;
      @(negedge clk);
      chk("R4 follows ext low", {15'd0, sub_freeze}, 16'h0);
      ext_freeze = 1'b1;
      @(negedge clk);
      bus_write(4'h0, 16'h0000);
      @(negedge clk);
      chk("R4 clearing enable releases", {15'd0, sub_freeze}, 16'h0);
      repeat (3) @(negedge clk);
      chk("R4 ext ignored when disabled", {15'd0, sub_freeze}, 16'h0);
      ext_freeze = 1'b0;
   endtask

   task automatic t_collide;
      bus_write(4'h0, 16'hC000);
      ext_freeze = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 stop+ext frozen", {15'd0, sub_freeze}, 16'h1);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h4000;
      ext_freeze = 1'b0;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      chk("R5 old stop still sampled", {15'd0, sub_freeze}, 16'h1);
      @(negedge clk);
      chk("R5 same-cycle release", {15'd0, sub_freeze}, 16'h0);
      bus_write(4'h0, 16'h0000);
   endtask

   task automatic t_vector;
      logic [5:0] subs [3];
      subs[0] = 6'h00; subs[1] = 6'h2A; subs[2] = 6'h3F;
      for (int c = 0; c < 4; c++) begin
         bus_write(4'h0, 16'(c) << 11);
         for (int s = 0; s < 3; s++) begin
            sub_num = subs[s];
            #1 chk("R7 vector join", {8'd0, irq_vector},
                   {8'd0, 8'(c * 64) | {2'b00, subs[s]}});
         end
      end
      bus_write(4'h0, 16'h0000);
   endtask

   task automatic t_slots;
      logic [15:0] d;
      bus_write(4'h0, 16'h0105);
      bus_write(4'h2, 16'hFFFF);
      bus_write(4'h4, 16'hFFFF);
      bus_read(4'h2, d);
      chk("R8 test slot reads zero", d, 16'h0);
      bus_read(4'h4, d);
      chk("R8 time-base slot reads zero", d, 16'h0);
      bus_read(4'h0, d);
      chk("R8 slot writes leave cfg", d, 16'h0105);
      bus_write(4'h6, 16'hFFFF);
      bus_write(4'h1, 16'hFFFF);
      bus_write(4'hE, 16'hFFFF);
      bus_read(4'h6, d);
      chk("R9 unmapped 0x6 zero", d, 16'h0);
      bus_read(4'h1, d);
      chk("R9 odd offset zero", d, 16'h0);
      bus_read(4'h0, d);
      chk("R9 unmapped writes leave cfg", d, 16'h0105);
      chk("R9 no freeze side effect", {15'd0, sub_freeze}, 16'h0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_stop();
      t_fen();
      t_collide();
      t_vector();
      t_slots();
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

endmodule